// File: doc/BRIEF.md
# Bus Device Response Data Scrubber

This block is the response half of a device-side adapter on a TileLink Uncached Lightweight (TL-UL) bus. A host request arrives on the A channel and is forwarded to a simple register or memory port. The read data and error indication that come back are returned on the D channel. Only one transaction is outstanding at a time. The response is held steady until the host takes it.

A parameter selects one of two device timings. In the zero-latency mode the device presents its data in the same cycle the request is accepted, and the block captures it in a register. In the one-latency mode the device answers one cycle later. The block forwards that answer combinationally and latches it at the same time, so a stalled response does not change.

Once a response has been taken and no new request is accepted in that cycle, the returned data bus is overwritten with all ones. The last read value therefore does not stay visible on the bus while the adapter is idle.

Top module: `rsp_scrub_adapter`

## Requirements
- R1: After reset, `rsp_data` is zero, `rsp_err` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read returns the device data. When `LATENCY`=0, `dev_rdata` is sampled in the cycle the request is accepted. When `LATENCY`=1, `dev_rdata` is used in the cycle after acceptance. In both modes `rsp_valid` rises in the cycle after acceptance.
- R3: For a write, for an asserted `dev_err`, or for an asserted `int_err`, `rsp_data` is all ones instead of the device data.
- R4: `rsp_err` equals `dev_err` OR `int_err`. `int_err` is sampled when the request is accepted. `dev_err` is sampled at the same point in time as `dev_rdata`.
- R5: `rsp_valid` stays high until `rsp_ready` is seen. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_data` and `rsp_err` do not change, whatever the device inputs do.
- R6: `req_ready` is 0 while a response is pending and `rsp_ready` is 0. Otherwise it is 1.
- R7: After a response handshake with no request accepted in the same cycle, `rsp_data` is all ones from the next cycle until the next response.
- R8: When a response handshake and a new request acceptance happen in the same cycle, the next cycle presents the new response, not the scrub pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A-channel request valid |
| req_ready | output | 1 | A-channel request ready |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| int_err | input | 1 | Adapter-internal error for the offered request |
| dev_req | output | 1 | Request strobe to the device port (the acceptance cycle) |
| dev_write | output | 1 | Write qualifier to the device port |
| dev_rdata | input | DW | Device read data |
| dev_err | input | 1 | Device error |
| rsp_valid | output | 1 | D-channel response valid |
| rsp_ready | input | 1 | D-channel response ready |
| rsp_data | output | DW | D-channel response data |
| rsp_err | output | 1 | D-channel response error |

## Verification
Both latency modes are run with every combination of read or write, device error and internal error, so each source that forces the data to ones is seen alone and in combination. Each combination is run with no stall, one stall cycle and two stall cycles. During the stalls the device inputs are changed, which shows whether the response comes from the held copy or from the live inputs. A response taken in its first cycle, and a response overlapped with the next request, separate the scrub from a back-to-back return. Idle handshakes after reset show that the reset value survives when no response has completed.

// File: rtl/rsp_scrub_pkg.sv
package rsp_scrub_pkg;

    // Control state shared by the handshake tracker.
    typedef struct packed {
        logic pend;      // response outstanding on D channel
        logic rd_first;  // one-latency: first response cycle of a read
        logic wr_first;  // one-latency: first response cycle of a write
        logic ierr;      // internal error captured at acceptance
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{pend: 1'b0, rd_first: 1'b0,
                                           wr_first: 1'b0, ierr: 1'b0};

endpackage

// File: rtl/rsp_scrub_ctrl.sv
module rsp_scrub_ctrl
    import rsp_scrub_pkg::*;
#(
    parameter int LATENCY = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic int_err,
    input  logic rsp_ready,
    output logic req_ready,
    output logic rsp_valid,
    output logic accept,
    output logic done,
    output logic rd_first,
    output logic wr_first,
    output logic ierr_q
);

    localparam bit LAT1 = (LATENCY != 0);

    ctrl_state_t st_d, st_q;

    always_comb begin
        req_ready = !st_q.pend || rsp_ready;
        accept    = req_valid && req_ready;
        done      = st_q.pend && rsp_ready;

        st_d = st_q;
        if (accept) begin
            st_d.pend = 1'b1;
        end else if (done) begin
            st_d.pend = 1'b0;
        end
        st_d.rd_first = LAT1 && accept && !req_write;
        st_d.wr_first = LAT1 && accept && req_write;
        st_d.ierr     = accept ? int_err : st_q.ierr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.pend;
    assign rd_first  = st_q.rd_first;
    assign wr_first  = st_q.wr_first;
    assign ierr_q    = st_q.ierr;

    // R5: a stalled response keeps its valid
    a_r5_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid);

    // R6: nothing new is taken while a response is stalled
    a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !accept);

    // R2: a first-cycle flag only follows an acceptance
    a_r2_first_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_first || wr_first) |-> $past(accept) && rsp_valid);

endmodule

// File: rtl/rsp_scrub_dpath.sv
module rsp_scrub_dpath #(
    parameter int DW      = 32,
    parameter int LATENCY = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          done,
    input  logic          req_write,
    input  logic          int_err,
    input  logic          rd_first,
    input  logic          wr_first,
    input  logic          ierr_q,
    input  logic [DW-1:0] dev_rdata,
    input  logic          dev_err,
    output logic [DW-1:0] hold_data,
    output logic          hold_err,
    output logic [DW-1:0] live_data,
    output logic          live_err
);

    localparam logic [DW-1:0] ONES = {DW{1'b1}};

    typedef struct packed {
        logic [DW-1:0] data;
        logic          err;
    } hold_t;

    hold_t h_d, h_q;
    logic  cap_err;
    logic  [DW-1:0] cap_data;

    // Capture path used by the zero-latency variant and the live path
    // used by the one-latency variant; generate picks which feeds the hold.
    always_comb begin
        cap_err  = dev_err || int_err;
        cap_data = (cap_err || req_write) ? ONES : dev_rdata;
        live_err  = dev_err || ierr_q;
        live_data = (live_err || wr_first) ? ONES : dev_rdata;
    end

    generate
        if (LATENCY == 0) begin : g_lat0
            always_comb begin
                h_d = h_q;
                if (accept) begin
                    h_d.data = cap_data;
                    h_d.err  = cap_err;
                end else if (done) begin
                    h_d.data = ONES;
                end
            end
        end else begin : g_lat1
            logic first;
            assign first = rd_first || wr_first;
            always_comb begin
                h_d = h_q;
                if (done && !accept) begin
                    h_d.data = ONES;
                end else if (first) begin
                    h_d.data = live_data;
                    h_d.err  = live_err;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign hold_data = h_q.data;
    assign hold_err  = h_q.err;

    // R7: a finished response with no follow-up leaves ones in the hold
    a_r7_hold_scrubbed: assert property (@(posedge clk) disable iff (!rst_n)
        done && !accept |=> hold_data == ONES);

endmodule

// File: rtl/rsp_scrub_outsel.sv
module rsp_scrub_outsel #(
    parameter int DW      = 32,
    parameter int LATENCY = 0
) (
    input  logic          rd_first,
    input  logic          wr_first,
    input  logic [DW-1:0] hold_data,
    input  logic          hold_err,
    input  logic [DW-1:0] live_data,
    input  logic          live_err,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_err
);

    generate
        if (LATENCY == 0) begin : g_reg_only
            assign rsp_data = hold_data;
            assign rsp_err  = hold_err;
        end else begin : g_pass
            logic first;
            assign first    = rd_first || wr_first;
            assign rsp_data = first ? live_data : hold_data;
            assign rsp_err  = first ? live_err : hold_err;
        end
    endgenerate

endmodule

// File: rtl/rsp_scrub_adapter.sv
module rsp_scrub_adapter #(
    parameter int DW      = 32,
    parameter int LATENCY = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          int_err,
    output logic          dev_req,
    output logic          dev_write,
    input  logic [DW-1:0] dev_rdata,
    input  logic          dev_err,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_err
);

    localparam logic [DW-1:0] ONES = {DW{1'b1}};

    logic          accept, done, rd_first, wr_first, ierr_q;
    logic [DW-1:0] hold_data, live_data;
    logic          hold_err, live_err;

    rsp_scrub_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .int_err(int_err),
        .rsp_ready(rsp_ready), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .accept(accept), .done(done), .rd_first(rd_first),
        .wr_first(wr_first), .ierr_q(ierr_q)
    );

    rsp_scrub_dpath #(.DW(DW), .LATENCY(LATENCY)) u_dpath (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .done(done), .req_write(req_write),
        .int_err(int_err), .rd_first(rd_first), .wr_first(wr_first),
        .ierr_q(ierr_q), .dev_rdata(dev_rdata), .dev_err(dev_err),
        .hold_data(hold_data), .hold_err(hold_err),
        .live_data(live_data), .live_err(live_err)
    );

    rsp_scrub_outsel #(.DW(DW), .LATENCY(LATENCY)) u_outsel (
        .rd_first(rd_first), .wr_first(wr_first),
        .hold_data(hold_data), .hold_err(hold_err),
        .live_data(live_data), .live_err(live_err),
        .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    assign dev_req   = accept;
    assign dev_write = req_write;

    // R5: stalled response data and error are frozen
    a_r5_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> $stable(rsp_data) && $stable(rsp_err));

    // R7: bus scrubbed to ones after a lone response handshake
    a_r7_scrub: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && !(req_valid && req_ready)
        |=> !rsp_valid && rsp_data == ONES);

    // R3: a write answers with all ones
    a_r3_write_ones: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write |=> rsp_valid && rsp_data == ONES);

    // R4: an internal error is reported on the response
    a_r4_int_err: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && int_err |=> rsp_err);

    // R8: overlapped handshake presents the next response
    a_r8_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && req_valid && req_ready |=> rsp_valid);

endmodule

// File: tb/rsp_scrub_adapter_bench.sv
`timescale 1ns/1ps
module rsp_scrub_adapter_bench;

    localparam int DW = 32;
    localparam logic [DW-1:0] ONES = {DW{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid [2];
    logic          req_ready [2];
    logic          req_write [2];
    logic          int_err   [2];
    logic          dev_req   [2];
    logic          dev_write [2];
    logic [DW-1:0] dev_rdata [2];
    logic          dev_err   [2];
    logic          rsp_valid [2];
    logic          rsp_ready [2];
    logic [DW-1:0] rsp_data  [2];
    logic          rsp_err   [2];

    // Index 0 is the zero-latency instance, index 1 the one-latency instance.
    rsp_scrub_adapter #(.DW(DW), .LATENCY(0)) u_rsp_scrub_adapter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[0]), .req_ready(req_ready[0]),
        .req_write(req_write[0]), .int_err(int_err[0]),
        .dev_req(dev_req[0]), .dev_write(dev_write[0]),
        .dev_rdata(dev_rdata[0]), .dev_err(dev_err[0]),
        .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]),
        .rsp_data(rsp_data[0]), .rsp_err(rsp_err[0])
    );

    rsp_scrub_adapter #(.DW(DW), .LATENCY(1)) u_rsp_scrub_adapter_l1 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[1]), .req_ready(req_ready[1]),
        .req_write(req_write[1]), .int_err(int_err[1]),
        .dev_req(dev_req[1]), .dev_write(dev_write[1]),
        .dev_rdata(dev_rdata[1]), .dev_err(dev_err[1]),
        .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]),
        .rsp_data(rsp_data[1]), .rsp_err(rsp_err[1])
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs(input int m);
        req_valid[m] = 1'b0; req_write[m] = 1'b0; int_err[m] = 1'b0;
        dev_rdata[m] = '0;   dev_err[m]   = 1'b0; rsp_ready[m] = 1'b0;
    endtask

    // Device value is presented in the acceptance cycle (mode 0)
    // or in the cycle after it (mode 1).
    task automatic txn(input int m, input bit we, input logic [DW-1:0] data,
                       input bit derr, input bit ierr, input int stall);
        logic [DW-1:0] exp_d;
        logic          exp_e;
        exp_e = derr | ierr;
        exp_d = (we | exp_e) ? ONES : data;
        @(negedge clk);
        req_valid[m] = 1'b1; req_write[m] = we; int_err[m] = ierr;
        rsp_ready[m] = 1'b0;
        dev_rdata[m] = (m == 0) ? data : ~data;
        dev_err[m]   = (m == 0) ? derr : !derr;
        #1 check($sformatf("R6 idle ready m%0d", m), req_ready[m], 1);
        @(negedge clk);
        req_valid[m] = 1'b0; int_err[m] = 1'b0;
        dev_rdata[m] = (m == 0) ? ~data : data;
        dev_err[m]   = (m == 0) ? !derr : derr;
        rsp_ready[m] = (stall == 0);
        #1;
        check($sformatf("R5 valid m%0d", m), rsp_valid[m], 1);
        check($sformatf("R2/R3 data m%0d we%0d de%0d ie%0d", m, we, derr, ierr),
              rsp_data[m], exp_d);
        check($sformatf("R4 err m%0d de%0d ie%0d", m, derr, ierr), rsp_err[m], exp_e);
        check($sformatf("R6 pending ready m%0d", m), req_ready[m], (stall == 0));
        for (int s = 1; s < stall + 1 && stall > 0; s++) begin
            @(negedge clk);
            dev_rdata[m] = data ^ 32'h5A5A_A5A5 ^ DW'(s);
            dev_err[m]   = !derr;
            rsp_ready[m] = (s == stall);
            #1;
            check($sformatf("R5 held data m%0d s%0d", m, s), rsp_data[m], exp_d);
            check($sformatf("R5 held err m%0d s%0d", m, s), rsp_err[m], exp_e);
            check($sformatf("R5 held valid m%0d", m), rsp_valid[m], 1);
        end
        @(negedge clk);
        rsp_ready[m] = 1'b0;
        dev_rdata[m] = 32'hDEAD_0000 ^ data;
        dev_err[m]   = 1'b0;
        #1;
        check($sformatf("R5 valid drop m%0d", m), rsp_valid[m], 0);
        check($sformatf("R7 scrub m%0d", m), rsp_data[m], ONES);
    endtask

    // Second request accepted in the same cycle as the first response.
    task automatic overlap(input int m, input logic [DW-1:0] d1,
                           input logic [DW-1:0] d2);
        @(negedge clk);
        req_valid[m] = 1'b1; req_write[m] = 1'b0; int_err[m] = 1'b0;
        dev_err[m] = 1'b0; rsp_ready[m] = 1'b0;
        dev_rdata[m] = (m == 0) ? d1 : '0;
        @(negedge clk);
        req_valid[m] = 1'b1; rsp_ready[m] = 1'b1;
        dev_rdata[m] = (m == 0) ? d2 : d1;
        #1;
        check($sformatf("R8 first data m%0d", m), rsp_data[m], d1);
        check($sformatf("R6 overlap ready m%0d", m), req_ready[m], 1);
        @(negedge clk);
        req_valid[m] = 1'b0; rsp_ready[m] = 1'b0;
        dev_rdata[m] = (m == 0) ? ~d2 : d2;
        #1;
        check($sformatf("R8 second valid m%0d", m), rsp_valid[m], 1);
        check($sformatf("R8 second data m%0d", m), rsp_data[m], d2);
        @(negedge clk);
        rsp_ready[m] = 1'b1;
        @(negedge clk);
        rsp_ready[m] = 1'b0;
        #1 check($sformatf("R7 scrub after overlap m%0d", m), rsp_data[m], ONES);
    endtask

    initial begin
        for (int m = 0; m < 2; m++) idle_inputs(m);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        for (int m = 0; m < 2; m++) begin
            check($sformatf("R1 data m%0d", m), rsp_data[m], '0);
            check($sformatf("R1 err m%0d", m), rsp_err[m], 0);
            check($sformatf("R1 valid m%0d", m), rsp_valid[m], 0);
            check($sformatf("R1 ready m%0d", m), req_ready[m], 1);
        end
        rst_n = 1'b1;
        // idle response-ready toggling must not disturb the reset value
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            rsp_ready[m] = 1'b1; dev_rdata[m] = 32'hFFFF_0000;
            repeat (2) @(negedge clk);
            rsp_ready[m] = 1'b0;
            #1;
            check($sformatf("R1 idle data m%0d", m), rsp_data[m], '0);
            check($sformatf("R1 idle valid m%0d", m), rsp_valid[m], 0);
        end
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 8; c++) begin
                for (int st = 0; st < 3; st++) begin
                    txn(m, c[0], 32'h1357_0000 + 32'h9E37_79B9 * (c * 3 + st + 1),
                        c[1], c[2], st);
                end
            end
            overlap(m, 32'h0BAD_F00D, 32'h600D_CAFE);
            overlap(m, 32'h0000_0001, 32'h8000_0000);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule